// File: doc/BRIEF.md
# SPI Master Event and Interrupt Unit

This block sits beside an SPI master's shift engine and FIFOs. It turns single-cycle event pulses from those neighbours into sticky flags. Software clears a flag by writing 1 to it. A mask register selects which flags may raise a single registered interrupt line. The same small register port also gives a read-only status word and a command word. In the status word, live FIFO and engine flags sit next to a summary bit that is set when any unmasked event is pending.

The command word issues two FIFO-clear requests and a transfer start. A FIFO-clear bit stays set and reads back as 1 until the FIFO acknowledges it. Software can therefore write the clear and poll until the command word reads zero. The start bit makes a one-cycle start pulse toward the shift engine and always reads back as 0. Writing start again while a transmit underflow is pending resumes a paused transfer.

Register select on `reg_addr`:
- 0: event flags, write 1 to clear.
- 1: mask, read/write.
- 2: status, read-only.
- 3: command.

Writes take effect at the clock edge that samples `reg_wr`. `reg_rdata` is a combinational view of the selected register.

Top module: `spi_evt_irq_unit`

## Requirements
- R1: After reset the event register reads 0, the mask reads all ones (0x1FF), the command word reads 0, `irq` is 0, and no clear or start request is driven.
- R2: A 1 on bit i of `evt_pulse` sets event bit i, and the bit stays set until software clears it. The bit map is:
  - bit 0: master done
  - bit 1: slave done
  - bit 2: transmit request
  - bit 3: receive request
  - bit 4: transmit overflow
  - bit 5: transmit underflow
  - bit 6: receive overflow
  - bit 7: receive underflow
  - bit 8: multiple-master error
- R3: Writing the event register clears every bit written as 1 and leaves every bit written as 0 unchanged.
- R4: When an event pulse and a write-one-to-clear of the same bit fall in the same cycle, the bit stays set.
- R5: A mask bit of 1 keeps its event from the interrupt. With all nine mask bits set, `irq` stays 0 whatever events are pending.
- R6: Status bit 0 reads 1 exactly when some event bit is set whose mask bit is 0. It follows the register contents in the same cycle.
- R7: `irq` is registered. It rises one cycle after status bit 0 becomes 1, and falls one cycle after the last unmasked pending event is cleared or masked.
- R8: Status bits 1 to 5 show the live inputs with no storage:
  - bit 1: `eng_ready`
  - bit 2: `txf_empty`
  - bit 3: `txf_full`
  - bit 4: `rxf_empty`
  - bit 5: `rxf_full`
- R9: Writing 1 to command bit 0 (receive FIFO clear) or command bit 1 (transmit FIFO clear) sets `rxf_clr_req` or `txf_clr_req`. The bit reads back as 1 until the matching acknowledge input is sampled high, and then reads back as 0.
- R10: Writing 1 to command bit 2 gives `xfer_start` high for exactly the next cycle, and command bit 2 reads back as 0. Every such write starts again, including while the transmit-underflow event is set.
- R11: Writes to the status register have no effect on the event, mask or status contents. The mask register reads back the value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 9 | Write data |
| reg_rdata | output | 9 | Read data of the selected register |
| evt_pulse | input | 9 | One-cycle event pulses, bit map as in R2 |
| eng_ready | input | 1 | Engine ready, live |
| txf_empty | input | 1 | Transmit FIFO empty, live |
| txf_full | input | 1 | Transmit FIFO full, live |
| rxf_empty | input | 1 | Receive FIFO empty, live |
| rxf_full | input | 1 | Receive FIFO full, live |
| rxf_clr_ack | input | 1 | Receive FIFO has finished clearing |
| txf_clr_ack | input | 1 | Transmit FIFO has finished clearing |
| rxf_clr_req | output | 1 | Receive FIFO clear request, held until acknowledged |
| txf_clr_req | output | 1 | Transmit FIFO clear request, held until acknowledged |
| xfer_start | output | 1 | One-cycle transfer start pulse |
| irq | output | 1 | Registered interrupt |

## Verification
A lost or stuck event flag shows as a wrong event read in the cycle after the pulse or the clear. One cycle after that it shows as a missing or lingering `irq`. A mask bit that is wrong changes status bit 0 at once, and `irq` one cycle later. The bench sweeps every event bit singly and a spread of mask and event patterns against an arithmetic expectation.

A clear request that never drops, or one that drops early, shows on the request pin and in the command readback within one cycle of the acknowledge. A start pulse that is missing, doubled or stretched shows on `xfer_start` in the cycle after the write.

// File: rtl/spi_evt_pkg.sv
package spi_evt_pkg;
  typedef enum logic [1:0] {
    SEL_EVENT  = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_STATUS = 2'd2,
    SEL_CMD    = 2'd3
  } reg_sel_e;

  localparam int EV_TX_UNDER = 5;

  localparam int CMD_RX_CLR = 0;
  localparam int CMD_TX_CLR = 1;
  localparam int CMD_START  = 2;
  localparam int CMD_W      = 3;

  localparam int ST_W = 6;

  function automatic logic [ST_W-1:0] pack_status(
    input logic pend, input logic rdy,
    input logic te, input logic tf,
    input logic re, input logic rf);
    return {rf, re, tf, te, rdy, pend};
  endfunction
endpackage

// File: rtl/spi_evt_bank.sv
module spi_evt_bank #(
  parameter int N_EVT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] pulse_i,
  input  logic [N_EVT-1:0] clr_i,
  output logic [N_EVT-1:0] evt_o
);
  logic [N_EVT-1:0] evt_q;

  for (genvar i = 0; i < N_EVT; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n)          evt_q[i] <= 1'b0;
      else if (pulse_i[i]) evt_q[i] <= 1'b1;
      else if (clr_i[i])   evt_q[i] <= 1'b0;
    end

    // R2: a set flag persists while no clear is written
    a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_q[i] && !clr_i[i]) |=> evt_q[i]);
    // R3: a clear without a pulse empties the bit
    a_r3_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[i] && !pulse_i[i]) |=> !evt_q[i]);
    // R4: a pulse always leaves the bit set
    a_r4_pulse_wins: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_i[i] |=> evt_q[i]);
  end

  assign evt_o = evt_q;
endmodule

// File: rtl/spi_irq_gen.sv
module spi_irq_gen #(
  parameter int N_EVT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mask_wr,
  input  logic [N_EVT-1:0] mask_wdata,
  input  logic [N_EVT-1:0] evt_i,
  output logic [N_EVT-1:0] mask_o,
  output logic             pend_o,
  output logic             irq_o
);
  logic [N_EVT-1:0] mask_q;
  logic             irq_q;
  logic             live_any;

  function automatic logic unmasked_any(input logic [N_EVT-1:0] ev,
                                        input logic [N_EVT-1:0] mk);
    return |(ev & ~mk);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_q <= '1;
    else if (mask_wr) mask_q <= mask_wdata;
  end

  assign live_any = unmasked_any(evt_i, mask_q);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= live_any;
  end

  assign mask_o = mask_q;
  assign pend_o = live_any;
  assign irq_o  = irq_q;

  // R5: a fully masked unit keeps the line quiet
  a_r5_all_masked: assert property (@(posedge clk) disable iff (!rst_n)
    ((&mask_q) && $past(&mask_q)) |-> !irq_q);
  // R7: the line falls only after the pending summary has dropped
  a_r7_fall_late: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> !$past(live_any));
endmodule

// File: rtl/spi_cmd_ctl.sv
module spi_cmd_ctl
  import spi_evt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_wdata,
  input  logic             rx_ack,
  input  logic             tx_ack,
  output logic             rx_req,
  output logic             tx_req,
  output logic             start_o
);
  logic rx_set, tx_set, start_set;
  logic rx_pend, tx_pend, start_q;

  assign rx_set    = cmd_wr && cmd_wdata[CMD_RX_CLR];
  assign tx_set    = cmd_wr && cmd_wdata[CMD_TX_CLR];
  assign start_set = cmd_wr && cmd_wdata[CMD_START];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_pend <= 1'b0;
      tx_pend <= 1'b0;
      start_q <= 1'b0;
    end else begin
      if (rx_set)      rx_pend <= 1'b1;
      else if (rx_ack) rx_pend <= 1'b0;
      if (tx_set)      tx_pend <= 1'b1;
      else if (tx_ack) tx_pend <= 1'b0;
      start_q <= start_set;
    end
  end

  assign rx_req  = rx_pend;
  assign tx_req  = tx_pend;
  assign start_o = start_q;

  // R9: a request is held until acknowledged
  a_r9_rx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_pend && !rx_ack) |=> rx_pend);
  a_r9_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pend && !tx_ack) |=> tx_pend);
  // R10: every start pulse is caused by a start write one cycle before
  a_r10_start_cause: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |-> $past(start_set));
endmodule

// File: rtl/spi_evt_irq_unit.sv
module spi_evt_irq_unit
  import spi_evt_pkg::*;
#(
  parameter int N_EVT = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [N_EVT-1:0] reg_wdata,
  output logic [N_EVT-1:0] reg_rdata,
  input  logic [N_EVT-1:0] evt_pulse,
  input  logic             eng_ready,
  input  logic             txf_empty,
  input  logic             txf_full,
  input  logic             rxf_empty,
  input  logic             rxf_full,
  input  logic             rxf_clr_ack,
  input  logic             txf_clr_ack,
  output logic             rxf_clr_req,
  output logic             txf_clr_req,
  output logic             xfer_start,
  output logic             irq
);
  localparam int PAD_ST  = N_EVT - ST_W;
  localparam int PAD_CMD = N_EVT - CMD_W;

  logic             wr_event, wr_mask, wr_cmd;
  logic [N_EVT-1:0] evt_clr;
  logic [N_EVT-1:0] evt_q, mask_q;
  logic             pend;
  logic [ST_W-1:0]  status;

  assign wr_event = reg_wr && (reg_addr == SEL_EVENT);
  assign wr_mask  = reg_wr && (reg_addr == SEL_MASK);
  assign wr_cmd   = reg_wr && (reg_addr == SEL_CMD);
  assign evt_clr  = wr_event ? reg_wdata : '0;

  spi_evt_bank #(.N_EVT(N_EVT)) u_bank (
    .clk(clk), .rst_n(rst_n), .pulse_i(evt_pulse), .clr_i(evt_clr),
    .evt_o(evt_q));

  spi_irq_gen #(.N_EVT(N_EVT)) u_irq (
    .clk(clk), .rst_n(rst_n), .mask_wr(wr_mask), .mask_wdata(reg_wdata),
    .evt_i(evt_q), .mask_o(mask_q), .pend_o(pend), .irq_o(irq));

  spi_cmd_ctl u_cmd (
    .clk(clk), .rst_n(rst_n), .cmd_wr(wr_cmd),
    .cmd_wdata(reg_wdata[CMD_W-1:0]), .rx_ack(rxf_clr_ack),
    .tx_ack(txf_clr_ack), .rx_req(rxf_clr_req), .tx_req(txf_clr_req),
    .start_o(xfer_start));

  assign status = pack_status(pend, eng_ready, txf_empty, txf_full,
                              rxf_empty, rxf_full);

  always_comb begin
    unique case (reg_sel_e'(reg_addr))
      SEL_EVENT:  reg_rdata = evt_q;
      SEL_MASK:   reg_rdata = mask_q;
      SEL_STATUS: reg_rdata = {{PAD_ST{1'b0}}, status};
      default:    reg_rdata = {{PAD_CMD{1'b0}}, 1'b0, txf_clr_req, rxf_clr_req};
    endcase
  end

  // R7: an unmasked pending event is followed by the interrupt next cycle
  a_r7_rise: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> irq);
  // R11: a mask write is what it reads back next cycle
  a_r11_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask |=> (mask_q == $past(reg_wdata)));
endmodule

// File: tb/sim_spi_evt_irq_unit.sv
`timescale 1ns/1ps
module sim_spi_evt_irq_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [8:0] reg_wdata = '0;
  logic [8:0] reg_rdata;
  logic [8:0] evt_pulse = '0;
  logic eng_ready = 0, txf_empty = 0, txf_full = 0, rxf_empty = 0, rxf_full = 0;
  logic rxf_clr_ack = 0, txf_clr_ack = 0;
  logic rxf_clr_req, txf_clr_req, xfer_start, irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spi_evt_irq_unit u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_pulse(evt_pulse),
    .eng_ready(eng_ready), .txf_empty(txf_empty), .txf_full(txf_full),
    .rxf_empty(rxf_empty), .rxf_full(rxf_full), .rxf_clr_ack(rxf_clr_ack),
    .txf_clr_ack(txf_clr_ack), .rxf_clr_req(rxf_clr_req),
    .txf_clr_req(txf_clr_req), .xfer_start(xfer_start), .irq(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [8:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [8:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [8:0] v);
    @(negedge clk);
    evt_pulse = v;
    @(negedge clk);
    evt_pulse = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [8:0] d, m, e, exp_ev;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    rd(2'd0, d); chk(d == 9'h000, "R1 event", d, 0);
    rd(2'd1, d); chk(d == 9'h1FF, "R1 mask", d, 9'h1FF);
    rd(2'd3, d); chk(d == 9'h000, "R1 cmd", d, 0);
    chk(irq == 0 && !xfer_start && !rxf_clr_req && !txf_clr_req, "R1 outs", irq, 0);

    // R11 mask readback
    wr(2'd1, 9'h000);
    rd(2'd1, d); chk(d == 9'h000, "R11 mask rb", d, 0);

    // R2 R3 R6 R7 sweep over each event bit
    for (int i = 0; i < 9; i++) begin
      pulse(9'(1 << i));
      rd(2'd0, d); chk(d == 9'(1 << i), "R2 set", d, 1 << i);
      rd(2'd2, d); chk(d[0] == 1'b1, "R6 pend", d[0], 1);
      chk(irq == 1'b0, "R7 not yet", irq, 0);
      @(negedge clk);
      chk(irq == 1'b1, "R7 rise", irq, 1);
      rd(2'd0, d); chk(d == 9'(1 << i), "R2 sticky", d, 1 << i);
      wr(2'd0, ~9'(1 << i));
      rd(2'd0, d); chk(d == 9'(1 << i), "R3 zero keeps", d, 1 << i);
      wr(2'd0, 9'(1 << i));
      rd(2'd0, d); chk(d == 9'h000, "R3 cleared", d, 0);
      chk(irq == 1'b1, "R7 lag", irq, 1);
      @(negedge clk);
      chk(irq == 1'b0, "R7 fall", irq, 0);
    end

    // R5 R6 patterns of mask and events
    for (int k = 0; k < 40; k++) begin
      m = 9'((k * 37 + 5) % 512);
      e = 9'((k * 113 + 1) % 512);
      wr(2'd1, m);
      pulse(e);
      rd(2'd2, d); chk(d[0] == |(e & ~m), "R6 pattern", d[0], |(e & ~m));
      @(negedge clk);
      chk(irq == |(e & ~m), "R5 irq pattern", irq, |(e & ~m));
      wr(2'd0, 9'h1FF);
      @(negedge clk);
    end

    // R5 all masked silences
    wr(2'd1, 9'h1FF);
    pulse(9'h1FF);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(irq == 1'b0, "R5 all masked", irq, 0);
    end
    rd(2'd0, d); chk(d == 9'h1FF, "R2 masked still latched", d, 9'h1FF);
    wr(2'd0, 9'h1FF);

    // R4 pulse beats clear
    pulse(9'h008);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 2'd0; reg_wdata = 9'h008; evt_pulse = 9'h008;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0; evt_pulse = '0;
    rd(2'd0, d); chk(d == 9'h008, "R4 pulse wins", d, 9'h008);
    wr(2'd0, 9'h008);

    // R8 live status inputs
    for (int v = 0; v < 32; v++) begin
      {rxf_full, rxf_empty, txf_full, txf_empty, eng_ready} = 5'(v);
      rd(2'd2, d); chk(d[5:1] == 5'(v), "R8 live", d[5:1], v);
    end
    {rxf_full, rxf_empty, txf_full, txf_empty, eng_ready} = 5'd0;

    // R11 status write ignored
    wr(2'd1, 9'h0A5);
    pulse(9'h012);
    wr(2'd2, 9'h1FF);
    rd(2'd1, d); chk(d == 9'h0A5, "R11 mask kept", d, 9'h0A5);
    rd(2'd0, d); chk(d == 9'h012, "R11 events kept", d, 9'h012);
    rd(2'd2, d); chk(d == 9'h001, "R11 status", d, 9'h001);
    wr(2'd0, 9'h1FF);

    // R9 receive FIFO clear
    wr(2'd3, 9'h001);
    chk(rxf_clr_req && !txf_clr_req, "R9 rx req", {rxf_clr_req, txf_clr_req}, 2);
    repeat (3) @(negedge clk);
    rd(2'd3, d); chk(d == 9'h001, "R9 rx held", d, 1);
    rxf_clr_ack = 1'b1;
    @(negedge clk);
    rxf_clr_ack = 1'b0;
    rd(2'd3, d); chk(d == 9'h000 && !rxf_clr_req, "R9 rx done", d, 0);

    // R9 both clears, acked separately
    wr(2'd3, 9'h003);
    rd(2'd3, d); chk(d == 9'h003, "R9 both", d, 3);
    txf_clr_ack = 1'b1;
    @(negedge clk);
    txf_clr_ack = 1'b0;
    rd(2'd3, d); chk(d == 9'h001, "R9 tx done first", d, 1);
    rxf_clr_ack = 1'b1;
    @(negedge clk);
    rxf_clr_ack = 1'b0;
    rd(2'd3, d); chk(d == 9'h000, "R9 all done", d, 0);

    // R10 start pulse and restart after transmit underflow
    wr(2'd3, 9'h004);
    chk(xfer_start == 1'b1, "R10 start", xfer_start, 1);
    rd(2'd3, d); chk(d[2] == 1'b0, "R10 reads 0", d[2], 0);
    @(negedge clk);
    chk(xfer_start == 1'b0, "R10 one cycle", xfer_start, 0);
    pulse(9'h020);
    wr(2'd3, 9'h004);
    chk(xfer_start == 1'b1, "R10 restart", xfer_start, 1);
    rd(2'd0, exp_ev); chk(exp_ev == 9'h020, "R10 underflow kept", exp_ev, 9'h020);
    @(negedge clk);
    chk(xfer_start == 1'b0, "R10 restart one cycle", xfer_start, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule